// File: doc/BRIEF.md
# Domain and Access Permission Checker

This block decides whether a memory access that has already matched a translation entry may go ahead. Each request carries the access type, the privilege of the requester and the entry's permission fields: a domain number, a 3-bit access-permission code, two stage-2 permission bits, the execute-never bits and a flag that marks an entry built from the long descriptor format. Beside the request sit a packed domain control word, with two bits per domain, and a few system control bits.

The check runs in a fixed order. A short-format entry first selects its domain field. A manager domain grants the access at once. A no-access or reserved domain raises a domain fault. A client domain goes on to the permission decode. The access-permission code is remapped for long-format entries and when the access-flag mode is on. It then sets the abort and writability for the requester's privilege. Writability, together with the write-implies-never-execute controls, sets execute-never. Any failure on an instruction fetch is a prefetch fault. Any other failure is a data fault, and a flag marks a data fault caused by the stage-2 bits alone.

The result is registered and comes out exactly one cycle after the request strobe. It is driven by a two-state controller. `ST_IDLE` means no result is being shown. `ST_REPORT` means the result register holds the verdict for the previous cycle's request. The transition `IDLE->REPORT` and the self-loop `REPORT->REPORT` are taken when the strobe is high. `REPORT->IDLE` and `IDLE->IDLE` are taken when it is low. Requests may arrive back to back, one per cycle.

Top module: `perm_chk`

## Requirements
- R1: `done` is high in the cycle after a cycle with `req_valid` high and low in the cycle after a cycle with `req_valid` low; back-to-back requests give one result per cycle.
- R2: During reset and in the cycle after `req_valid` is low, `done`, `fault_class`, `fault_s2` and `fault_pf` are all zero.
- R3: For a short-format entry (`ent_long`=0), the domain field is `dac_word[2*ent_domain+1 : 2*ent_domain]`. A long-format entry skips the domain check and never gives a domain fault.
- R4: A domain field of 0 (no access) or 2 (reserved) gives `fault_class`=2'b01. `fault_pf` is 1 if the access is a fetch and 0 otherwise.
- R5: A domain field of 3 (manager) gives `fault_class`=2'b00 whatever the access-permission, stage-2 and execute-never bits are. A field of 1 (client) goes on to the permission checks.
- R6: The effective access-permission code is computed in two steps. For a long-format entry it is `{ent_ap[1:0],1'b0}`; otherwise it is `ent_ap`. Bit 0 is then forced to 1 when `ctl_afe`=1 or the entry is long-format.
- R7: The effective code gives the access-permission abort as follows. 0 and 4 abort every access. 1 aborts unprivileged accesses. 2 aborts unprivileged writes. 3 never aborts. 5 aborts unprivileged accesses and all writes. 6 and 7 abort writes.
- R8: A page is writable at the current privilege for codes 1 and 2 when privileged, for code 3 always, and otherwise never. Execute-never holds when `ent_xn`=1, or when the page is writable and `ctl_wxn`=1, or when the code is 3, `ctl_uwxn`=1 and the access is privileged.
- R9: The stage-2 check fails a write when `ent_hap[1]`=0. It fails a read or fetch when `ent_hap[0]`=0.
- R10: A fetch gives `fault_class`=2'b10 with `fault_pf`=1 when any of these hold: an access-permission abort, execute-never, a long-format entry with `ent_pxn`=1 fetched at privileged level, or a stage-2 failure.
- R11: A read or write with an access-permission abort or a stage-2 failure gives `fault_class`=2'b11 with `fault_pf`=0. `fault_s2`=1 only when the stage-2 check failed and the access-permission check did not.
- R12: `acc_kind` encodes 2'b00 read, 2'b01 write, 2'b10 fetch and 2'b11 read. `acc_priv`=1 means privileged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe |
| acc_kind | input | 2 | Access type (R12) |
| acc_priv | input | 1 | Privileged requester |
| ent_domain | input | 4 | Entry domain number |
| ent_ap | input | 3 | Entry access-permission code |
| ent_hap | input | 2 | Stage-2 permission bits (bit 1 write, bit 0 read) |
| ent_xn | input | 1 | Entry execute-never |
| ent_pxn | input | 1 | Entry privileged execute-never |
| ent_long | input | 1 | Entry is long-format |
| dac_word | input | 32 | Packed domain control word |
| ctl_afe | input | 1 | Access-flag mode, remaps the code |
| ctl_wxn | input | 1 | Writable implies execute-never |
| ctl_uwxn | input | 1 | Code 3 pages are never executed privileged |
| done | output | 1 | Result valid |
| fault_class | output | 2 | 00 none, 01 domain, 10 prefetch permission, 11 data permission |
| fault_s2 | output | 1 | Data fault caused only by the stage-2 check |
| fault_pf | output | 1 | Fault raised on an instruction fetch |

## Verification
The hardest cases to reach are those where only one side condition changes the verdict. Examples are the privileged fetch of a code-3 page that fails only through the unprivileged-write execute-never rule, a remapped long-format code that aborts only because of the shift, and a data fault that the stage-2 bits alone cause. None of these shows up unless the domain field, the remap controls and the stage-2 bits are all set up together. The stimulus therefore runs directed vectors for each such combination under a mixed domain word. It then sweeps every combination of code, access type, privilege, remap, execute-never controls and stage-2 bits under an all-client domain word, with idle cycles between groups. Each cycle is compared against a behavioural model.

// File: rtl/perm_pkg.sv
package perm_pkg;

    typedef enum logic [1:0] {
        ACC_READ     = 2'b00,
        ACC_WRITE    = 2'b01,
        ACC_FETCH    = 2'b10,
        ACC_READ_ALT = 2'b11
    } acc_kind_e;

    typedef enum logic [1:0] {
        FC_NONE     = 2'b00,
        FC_DOMAIN   = 2'b01,
        FC_PREFETCH = 2'b10,
        FC_DATA     = 2'b11
    } fault_class_e;

    typedef enum logic [1:0] {
        DOM_NOACC   = 2'b00,
        DOM_CLIENT  = 2'b01,
        DOM_RSVD    = 2'b10,
        DOM_MANAGER = 2'b11
    } dom_kind_e;

    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_REPORT = 1'b1
    } chk_state_e;

    typedef struct packed {
        fault_class_e cls;
        logic         s2;
        logic         pf;
    } verdict_t;

    localparam int AP_W  = 3;
    localparam int HAP_W = 2;

endpackage

// File: rtl/perm_dom_sel.sv
module perm_dom_sel
    import perm_pkg::*;
#(
    parameter int NUM_DOM   = 16,
    parameter int DOM_IDX_W = $clog2(NUM_DOM)
) (
    input  logic [2*NUM_DOM-1:0] dac_word,
    input  logic [DOM_IDX_W-1:0] dom_idx,
    output dom_kind_e            dom_kind
);
    localparam int FIELD_W = 2;

    logic [FIELD_W-1:0] fields [NUM_DOM];

    for (genvar g = 0; g < NUM_DOM; g++) begin : g_field
        assign fields[g] = dac_word[FIELD_W*g +: FIELD_W];
    end

    always_comb begin
        if (int'(dom_idx) < NUM_DOM) begin
            dom_kind = dom_kind_e'(fields[dom_idx]);
        end else begin
            dom_kind = DOM_NOACC;
        end
    end

endmodule

// File: rtl/perm_ap_decode.sv
module perm_ap_decode
    import perm_pkg::*;
(
    input  logic [AP_W-1:0] ap_raw,
    input  logic            long_fmt,
    input  logic            afe,
    input  logic            priv,
    input  logic            is_write,
    output logic [AP_W-1:0] ap_eff,
    output logic            ap_abort,
    output logic            writable
);
    logic [AP_W-1:0] ap_shift;

    always_comb begin
        ap_shift = long_fmt ? {ap_raw[AP_W-2:0], 1'b0} : ap_raw;
        ap_eff   = ap_shift;
        if (afe || long_fmt) begin
            ap_eff[0] = 1'b1;
        end
    end

    always_comb begin
        ap_abort = 1'b1;
        writable = 1'b0;
        unique case (ap_eff)
            3'd0: begin
                ap_abort = 1'b1;
                writable = 1'b0;
            end
            3'd1: begin
                ap_abort = !priv;
                writable = priv;
            end
            3'd2: begin
                ap_abort = !priv && is_write;
                writable = priv;
            end
            3'd3: begin
                ap_abort = 1'b0;
                writable = 1'b1;
            end
            3'd4: begin
                ap_abort = 1'b1;
                writable = 1'b0;
            end
            3'd5: begin
                ap_abort = !priv || is_write;
                writable = 1'b0;
            end
            3'd6, 3'd7: begin
                ap_abort = is_write;
                writable = 1'b0;
            end
            default: begin
                ap_abort = 1'b1;
                writable = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/perm_exec_eval.sv
module perm_exec_eval
    import perm_pkg::*;
(
    input  logic [AP_W-1:0]  ap_eff,
    input  logic             writable,
    input  logic             priv,
    input  logic             is_write,
    input  logic             xn,
    input  logic             pxn,
    input  logic             long_fmt,
    input  logic             wxn,
    input  logic             uwxn,
    input  logic [HAP_W-1:0] hap,
    output logic             exec_never,
    output logic             pxn_block,
    output logic             hap_abort
);
    localparam logic [AP_W-1:0] AP_FULL = 3'd3;

    logic wxn_hit;
    logic uwxn_hit;

    always_comb begin
        wxn_hit    = writable && wxn;
        uwxn_hit   = (ap_eff == AP_FULL) && uwxn && priv;
        exec_never = xn || wxn_hit || uwxn_hit;
        pxn_block  = long_fmt && pxn && priv;
        hap_abort  = is_write ? !hap[1] : !hap[0];
    end

endmodule

// File: rtl/perm_chk.sv
module perm_chk
    import perm_pkg::*;
#(
    parameter int NUM_DOM   = 16,
    parameter int DOM_IDX_W = $clog2(NUM_DOM),
    parameter int DAC_W     = 2 * NUM_DOM
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    input  logic [1:0]           acc_kind,
    input  logic                 acc_priv,
    input  logic [DOM_IDX_W-1:0] ent_domain,
    input  logic [2:0]           ent_ap,
    input  logic [1:0]           ent_hap,
    input  logic                 ent_xn,
    input  logic                 ent_pxn,
    input  logic                 ent_long,
    input  logic [DAC_W-1:0]     dac_word,
    input  logic                 ctl_afe,
    input  logic                 ctl_wxn,
    input  logic                 ctl_uwxn,
    output logic                 done,
    output logic [1:0]           fault_class,
    output logic                 fault_s2,
    output logic                 fault_pf
);
    chk_state_e      state_q;
    chk_state_e      state_d;
    dom_kind_e       dom_kind;
    logic [AP_W-1:0] ap_eff;
    logic            ap_abort;
    logic            writable;
    logic            exec_never;
    logic            pxn_block;
    logic            hap_abort;
    logic            is_write;
    logic            is_fetch;
    verdict_t        verdict;
    verdict_t        result_q;

    always_comb begin
        is_write = (acc_kind_e'(acc_kind) == ACC_WRITE);
        is_fetch = (acc_kind_e'(acc_kind) == ACC_FETCH);
    end

    perm_dom_sel #(
        .NUM_DOM   (NUM_DOM),
        .DOM_IDX_W (DOM_IDX_W)
    ) u_dom (
        .dac_word (dac_word),
        .dom_idx  (ent_domain),
        .dom_kind (dom_kind)
    );

    perm_ap_decode u_ap (
        .ap_raw   (ent_ap),
        .long_fmt (ent_long),
        .afe      (ctl_afe),
        .priv     (acc_priv),
        .is_write (is_write),
        .ap_eff   (ap_eff),
        .ap_abort (ap_abort),
        .writable (writable)
    );

    perm_exec_eval u_exec (
        .ap_eff     (ap_eff),
        .writable   (writable),
        .priv       (acc_priv),
        .is_write   (is_write),
        .xn         (ent_xn),
        .pxn        (ent_pxn),
        .long_fmt   (ent_long),
        .wxn        (ctl_wxn),
        .uwxn       (ctl_uwxn),
        .hap        (ent_hap),
        .exec_never (exec_never),
        .pxn_block  (pxn_block),
        .hap_abort  (hap_abort)
    );

    // Combinational verdict: domain gate first, then permission split.
    always_comb begin
        verdict = '{cls: FC_NONE, s2: 1'b0, pf: 1'b0};
        if (!ent_long && (dom_kind == DOM_NOACC || dom_kind == DOM_RSVD)) begin
            verdict.cls = FC_DOMAIN;
            verdict.pf  = is_fetch;
        end else if (!ent_long && dom_kind == DOM_MANAGER) begin
            verdict.cls = FC_NONE;
        end else if (is_fetch) begin
            if (ap_abort || exec_never || pxn_block || hap_abort) begin
                verdict.cls = FC_PREFETCH;
                verdict.pf  = 1'b1;
            end
        end else if (ap_abort || hap_abort) begin
            verdict.cls = FC_DATA;
            verdict.s2  = !ap_abort;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   state_d = req_valid ? ST_REPORT : ST_IDLE;
            ST_REPORT: state_d = req_valid ? ST_REPORT : ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result_q <= '{cls: FC_NONE, s2: 1'b0, pf: 1'b0};
        end else if (req_valid) begin
            result_q <= verdict;
        end else begin
            result_q <= '{cls: FC_NONE, s2: 1'b0, pf: 1'b0};
        end
    end

    assign done        = (state_q == ST_REPORT);
    assign fault_class = result_q.cls;
    assign fault_s2    = result_q.s2;
    assign fault_pf    = result_q.pf;

endmodule

// File: rtl/perm_chk_sva.sv
module perm_chk_sva #(
    parameter int NUM_DOM   = 16,
    parameter int DOM_IDX_W = $clog2(NUM_DOM),
    parameter int DAC_W     = 2 * NUM_DOM
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 req_valid,
    input logic [1:0]           acc_kind,
    input logic                 ent_long,
    input logic [DOM_IDX_W-1:0] ent_domain,
    input logic [DAC_W-1:0]     dac_word,
    input logic                 done,
    input logic [1:0]           fault_class,
    input logic                 fault_s2,
    input logic                 fault_pf
);
    logic [1:0] dom_field;
    assign dom_field = dac_word[{ent_domain, 1'b0} +: 2];

    // R1
    done_after_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> done);

    // R2
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!done && fault_class == 2'b00 && !fault_s2 && !fault_pf));

    // R3
    long_no_domain_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && ent_long) |=> (fault_class != 2'b01));

    // R4
    domain_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !ent_long && !dom_field[0]) |=>
            (fault_class == 2'b01));

    // R4
    domain_pf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !ent_long && !dom_field[0]) |=>
            (fault_pf == $past(acc_kind == 2'b10)));

    // R5
    manager_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !ent_long && dom_field == 2'b11) |=>
            (fault_class == 2'b00));

    // R10
    prefetch_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_class == 2'b10) |-> fault_pf);

    // R11
    s2_only_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault_s2 |-> (fault_class == 2'b11 && !fault_pf));

endmodule

bind perm_chk perm_chk_sva #(
    .NUM_DOM   (NUM_DOM),
    .DOM_IDX_W (DOM_IDX_W),
    .DAC_W     (DAC_W)
) u_sva (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .acc_kind    (acc_kind),
    .ent_long    (ent_long),
    .ent_domain  (ent_domain),
    .dac_word    (dac_word),
    .done        (done),
    .fault_class (fault_class),
    .fault_s2    (fault_s2),
    .fault_pf    (fault_pf)
);

// File: tb/sim_perm_chk.sv
module sim_perm_chk;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  acc_kind = 2'b00;
    logic        acc_priv = 1'b0;
    logic [3:0]  ent_domain = 4'd0;
    logic [2:0]  ent_ap = 3'd0;
    logic [1:0]  ent_hap = 2'b11;
    logic        ent_xn = 1'b0;
    logic        ent_pxn = 1'b0;
    logic        ent_long = 1'b0;
    logic [31:0] dac_word = 32'h5555_5555;
    logic        ctl_afe = 1'b0;
    logic        ctl_wxn = 1'b0;
    logic        ctl_uwxn = 1'b0;
    logic        done;
    logic [1:0]  fault_class;
    logic        fault_s2;
    logic        fault_pf;

    int vectors = 0;
    int miscompares = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    perm_chk u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .acc_kind    (acc_kind),
        .acc_priv    (acc_priv),
        .ent_domain  (ent_domain),
        .ent_ap      (ent_ap),
        .ent_hap     (ent_hap),
        .ent_xn      (ent_xn),
        .ent_pxn     (ent_pxn),
        .ent_long    (ent_long),
        .dac_word    (dac_word),
        .ctl_afe     (ctl_afe),
        .ctl_wxn     (ctl_wxn),
        .ctl_uwxn    (ctl_uwxn),
        .done        (done),
        .fault_class (fault_class),
        .fault_s2    (fault_s2),
        .fault_pf    (fault_pf)
    );

    // Behavioural model: returns {done, class[1:0], s2, pf}
    function automatic logic [4:0] model(input logic v, input logic [1:0] k,
                                         input logic p, input logic [3:0] d,
                                         input logic [2:0] a, input logic [1:0] h,
                                         input logic x, input logic px,
                                         input logic lf);
        int  field;
        int  code;
        bit  wr, fe, abt, wable, never, hfail;
        if (!v) return 5'b0;
        wr = (k == 2'd1);
        fe = (k == 2'd2);
        if (!lf) begin
            field = (dac_word >> (2 * d)) & 3;
            if (field == 0 || field == 2) return {1'b1, 2'd1, 1'b0, fe};
            if (field == 3) return {1'b1, 2'd0, 2'b00};
        end
        code = lf ? (a % 4) * 2 : a;
        if (ctl_afe || lf) code = code | 1;
        case (code)
            1: abt = !p;
            2: abt = !p && wr;
            3: abt = 0;
            5: abt = !p || wr;
            6, 7: abt = wr;
            default: abt = 1;
        endcase
        if (code == 1 || code == 2) wable = p;
        else wable = (code == 3);
        never = x || (wable && ctl_wxn) || (code == 3 && ctl_uwxn && p);
        hfail = wr ? !h[1] : !h[0];
        if (fe) begin
            if (abt || never || (lf && px && p) || hfail) return {1'b1, 2'd2, 1'b0, 1'b1};
            return {1'b1, 2'd0, 2'b00};
        end
        if (abt || hfail) return {1'b1, 2'd3, !abt, 1'b0};
        return {1'b1, 2'd0, 2'b00};
    endfunction

    function automatic string auto_tag(input logic [4:0] e);
        if (!e[4]) return "R2";
        case (e[3:2])
            2'd1: return "R4";
            2'd2: return "R10";
            2'd3: return "R11";
            default: return "R7";
        endcase
    endfunction

    task automatic compare(input logic [4:0] e, input string tag);
        logic [4:0] got;
        got = {done, fault_class, fault_s2, fault_pf};
        vectors++;
        if (got !== e) begin
            miscompares++;
            $display("FAIL %s: got done=%b cls=%b s2=%b pf=%b expected done=%b cls=%b s2=%b pf=%b",
                     (got[4] !== e[4]) ? "R1" : tag,
                     got[4], got[3:2], got[1], got[0], e[4], e[3:2], e[1], e[0]);
        end
    endtask

    // Drive at a falling edge, compare at the next falling edge.
    task automatic apply(input logic v, input logic [1:0] k, input logic p,
                         input logic [3:0] d, input logic [2:0] a,
                         input logic [1:0] h, input logic x, input logic px,
                         input logic lf, input string tag);
        logic [4:0] e;
        req_valid = v; acc_kind = k; acc_priv = p; ent_domain = d;
        ent_ap = a; ent_hap = h; ent_xn = x; ent_pxn = px; ent_long = lf;
        e = model(v, k, p, d, a, h, x, px, lf);
        @(negedge clk);
        compare(e, (tag == "") ? auto_tag(e) : tag);
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog: got timeout expected completion");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        compare(5'b0, "R2");
        rst_n = 1'b1;
        @(negedge clk);

        // R3: mixed domain word, fields repeat 0,1,2,3 per domain
        dac_word = 32'hE4E4_E4E4;
        apply(1, 2'd0, 1, 4'd0,  3'd3, 2'b11, 0, 0, 0, "R3");
        apply(1, 2'd0, 0, 4'd1,  3'd3, 2'b11, 0, 0, 0, "R3");
        apply(1, 2'd2, 1, 4'd2,  3'd3, 2'b11, 0, 0, 0, "R3");
        apply(1, 2'd1, 0, 4'd13, 3'd1, 2'b11, 0, 0, 0, "R3");
        apply(1, 2'd0, 0, 4'd4,  3'd0, 2'b11, 0, 0, 1, "R3");
        apply(0, 2'd2, 1, 4'd0,  3'd0, 2'b00, 1, 1, 0, "R2");
        // R5: manager ignores every permission bit
        apply(1, 2'd2, 0, 4'd15, 3'd0, 2'b00, 1, 1, 0, "R5");
        apply(1, 2'd1, 0, 4'd3,  3'd5, 2'b00, 0, 0, 0, "R5");

        dac_word = 32'h5555_5555;
        // R6: remapping of the code
        apply(1, 2'd0, 0, 4'd0, 3'd0, 2'b11, 0, 0, 1, "R6");
        apply(1, 2'd1, 0, 4'd0, 3'd1, 2'b11, 0, 0, 1, "R6");
        ctl_afe = 1'b1;
        apply(1, 2'd1, 1, 4'd0, 3'd4, 2'b11, 0, 0, 0, "R6");
        apply(1, 2'd1, 0, 4'd0, 3'd2, 2'b11, 0, 0, 0, "R6");
        ctl_afe = 1'b0;
        // R8: execute-never rules
        ctl_uwxn = 1'b1;
        apply(1, 2'd2, 1, 4'd0, 3'd3, 2'b11, 0, 0, 0, "R8");
        apply(1, 2'd2, 0, 4'd0, 3'd3, 2'b11, 0, 0, 0, "R8");
        ctl_uwxn = 1'b0;
        ctl_wxn = 1'b1;
        apply(1, 2'd2, 0, 4'd0, 3'd3, 2'b11, 0, 0, 0, "R8");
        apply(1, 2'd2, 0, 4'd0, 3'd6, 2'b11, 0, 0, 0, "R8");
        ctl_wxn = 1'b0;
        apply(1, 2'd2, 1, 4'd0, 3'd2, 2'b11, 0, 1, 1, "R10");
        // R9: stage-2 bits alone
        apply(1, 2'd1, 1, 4'd0, 3'd3, 2'b01, 0, 0, 0, "R9");
        apply(1, 2'd0, 1, 4'd0, 3'd3, 2'b10, 0, 0, 0, "R9");
        apply(1, 2'd2, 1, 4'd0, 3'd3, 2'b10, 0, 0, 0, "R9");
        // R12: code 3 of the access kind reads
        apply(1, 2'd3, 0, 4'd0, 3'd6, 2'b01, 0, 0, 0, "R12");
        apply(1, 2'd1, 0, 4'd0, 3'd6, 2'b11, 0, 0, 0, "R12");
        apply(0, 2'd0, 0, 4'd0, 3'd0, 2'b00, 0, 0, 0, "R2");

        // Full sweep under an all-client word
        for (int ctl = 0; ctl < 8; ctl++) begin
            ctl_afe  = ctl[0];
            ctl_wxn  = ctl[1];
            ctl_uwxn = ctl[2];
            for (int ap = 0; ap < 8; ap++) begin
                for (int k = 0; k < 4; k++) begin
                    for (int b = 0; b < 64; b++) begin
                        apply(1, 2'(k), b[0], 4'(ap + k), 3'(ap), b[2:1],
                              b[3], b[4], b[5], "");
                    end
                end
                apply(0, 2'(ap), 1, 4'd0, 3'(ap), 2'b00, 1, 1, 1, "");
            end
        end

        summary();
    end

endmodule